// File: doc/BRIEF.md
# Trace Buffer Write and Status Unit

This block takes a stream of trace bytes, one per handshake, and writes each byte to a circular region of memory. A write pointer advances one byte at a time between a base address and a limit address. When a byte lands on the last address below the limit, the pointer returns to the base. In wrap mode, collection simply continues from the base. In fill mode, collection halts once the region is full.

The block also keeps a 64-bit status word. This word records the following:
- a sticky wrap flag;
- a sticky trigger flag;
- a stopped flag;
- the maintenance interrupt;
- whether a byte is still waiting to reach memory;
- an event class;
- a 6-bit code that holds either the stop reason or the reported fault status.

Software reads this word and writes it to acknowledge events and to restart collection. A one-entry holding register sits between byte acceptance and the memory write port. This means a byte accepted on one edge is presented to memory from the next cycle.

Top module: `tbuf_wr_status`

## Requirements
- R1: Each accepted byte is written at the current pointer. If the pointer equals limit minus one, it reloads to base. Otherwise it increments. A reload sets the sticky wrap flag at status bit 20. `ptr_load_i` reloads the pointer to base.
- R2: In wrap mode (`wrap_mode_i`=1), a reload leaves collection running. The stopped bit stays 0 and `byte_ready_o` stays 1.
- R3: In fill mode (`wrap_mode_i`=0), a reload stops collection. The stopped bit (bit 17) becomes 1 and the code field [5:0] becomes 1. The byte written at limit minus one is still written.
- R4: A trigger pulse sets the sticky trigger flag (bit 21). If collection is running, the pulse also stops it with code 2.
- R5: A manual-stop pulse stops a running collection with code 3.
- R6: A write fault stops collection. It loads event class [31:26] with 0x24 for stage 1 or 0x25 for stage 2, and it loads [5:0] with the fault code. When no fault is recorded, the event class is 0.
- R7: While stopped, `byte_ready_o` is 0 and no further input byte reaches memory.
- R8: Status bit 22 equals `irq_o`. It sets whenever a stop or a fault is recorded, and it stays set until a software write clears it.
- R9: Status bit 23 is 1 while the holding register is occupied. While `mem_ready_i` is 0, the pending write keeps a stable address and stable data.
- R10: A software write loads the event class, interrupt, trigger, wrap, stopped and code fields from their own bit positions. All other bits read 0. A hardware event in the same cycle overrides the written value.
- R11: After reset, the status word is 0, `irq_o` is 0, `byte_ready_o` is 1 and no memory write is issued.
- R12: Once stopped, a later trigger or manual stop keeps the recorded code. Among simultaneous stop causes, fault beats fill wrap, fill wrap beats trigger, and trigger beats manual stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Trace byte offered |
| byte_data_i | input | DW | Trace byte |
| byte_ready_o | output | 1 | Byte accepted when high with valid |
| base_i | input | AW | Base address of the buffer region |
| limit_i | input | AW | Limit address (exclusive) |
| ptr_load_i | input | 1 | Reload write pointer to base |
| wrap_mode_i | input | 1 | 1 = wrap mode, 0 = fill mode |
| trig_i | input | 1 | Trigger pulse |
| man_stop_i | input | 1 | Manual stop pulse |
| fault_i | input | 1 | Write fault report |
| fault_stage2_i | input | 1 | Fault came from stage 2 |
| fault_code_i | input | 6 | Fault status code |
| sts_we_i | input | 1 | Software write of status word |
| sts_wdata_i | input | 64 | Software write data |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Memory write address |
| mem_data_o | output | DW | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the write |
| irq_o | output | 1 | Maintenance interrupt |
| status_o | output | 64 | Status word |

## Verification
The assertions assume the following about the inputs:
- `base_i` is below `limit_i`.
- Base and limit stay fixed while bytes flow.
- The pointer has been reloaded inside the region before streaming starts.
- Memory is never made to see a new write while one is held.

The bench holds to these assumptions. It changes base and limit only around a `ptr_load_i` pulse, and it drives every input at the falling edge. It sweeps several base and limit pairs, including a one-byte region, and computes each expected address as base plus the byte index modulo the region size.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  localparam logic [5:0] EC_BUF = 6'b000000;
  localparam logic [5:0] EC_S1  = 6'b100100;
  localparam logic [5:0] EC_S2  = 6'b100101;

  localparam logic [5:0] CODE_RUN  = 6'd0;
  localparam logic [5:0] CODE_FILL = 6'd1;
  localparam logic [5:0] CODE_TRIG = 6'd2;
  localparam logic [5:0] CODE_MAN  = 6'd3;

  localparam int EC_LSB   = 26;
  localparam int DAT_BIT  = 23;
  localparam int IRQ_BIT  = 22;
  localparam int TRG_BIT  = 21;
  localparam int WRAP_BIT = 20;
  localparam int STOP_BIT = 17;

  typedef struct packed {
    logic [5:0] ec;
    logic       irq;
    logic       trg;
    logic       wrap;
    logic       stop;
    logic [5:0] code;
  } tbuf_sts_t;

  function automatic logic [63:0] pack_status(tbuf_sts_t s, logic dat);
    logic [63:0] w;
    w = '0;
    w[EC_LSB +: 6] = s.ec;
    w[DAT_BIT]     = dat;
    w[IRQ_BIT]     = s.irq;
    w[TRG_BIT]     = s.trg;
    w[WRAP_BIT]    = s.wrap;
    w[STOP_BIT]    = s.stop;
    w[5:0]         = s.code;
    return w;
  endfunction
endpackage

// File: rtl/tbuf_ptr.sv
module tbuf_ptr #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic          acc_i,
  output logic [AW-1:0] wp_o,
  output logic          wrap_o
);
  logic [AW-1:0] wp_q;
  logic [AW-1:0] last;

  assign last   = limit_i - AW'(1);
  assign wrap_o = acc_i && (wp_q == last);
  assign wp_o   = wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wp_q <= '0;
    else if (load_i) wp_q <= base_i;
    else if (acc_i)  wp_q <= wrap_o ? base_i : wp_q + AW'(1);
  end

  // R1
  wp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !load_i |=> (wp_q == $past(base_i)) || (wp_q == ($past(wp_q) + AW'(1))));
endmodule

// File: rtl/tbuf_hold.sv
module tbuf_hold #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          mem_ready_i,
  output logic          full_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  logic          full_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (acc_i) begin
        full_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end else if (mem_ready_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o     = full_q;
  assign mem_we_o   = full_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_ready_i |=> mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o));
endmodule

// File: rtl/tbuf_stat.sv
module tbuf_stat
  import tbuf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wrap_ev_i,
  input  logic        fill_mode_i,
  input  logic        trig_i,
  input  logic        man_stop_i,
  input  logic        fault_i,
  input  logic        fault_stage2_i,
  input  logic [5:0]  fault_code_i,
  input  logic        sw_we_i,
  input  logic [63:0] sw_wdata_i,
  output tbuf_sts_t   sts_o
);
  tbuf_sts_t sts_q, sts_d;
  logic      unused_wd;

  assign unused_wd = ^{sw_wdata_i[63:32], sw_wdata_i[25:23], sw_wdata_i[19:18],
                       sw_wdata_i[16:6]};

  always_comb begin
    sts_d = sts_q;
    if (sw_we_i) begin
      sts_d.ec   = sw_wdata_i[EC_LSB +: 6];
      sts_d.irq  = sw_wdata_i[IRQ_BIT];
      sts_d.trg  = sw_wdata_i[TRG_BIT];
      sts_d.wrap = sw_wdata_i[WRAP_BIT];
      sts_d.stop = sw_wdata_i[STOP_BIT];
      sts_d.code = sw_wdata_i[5:0];
    end
    if (trig_i)    sts_d.trg  = 1'b1;
    if (wrap_ev_i) sts_d.wrap = 1'b1;
    // stop cause priority: fault, fill wrap, trigger, manual
    if (fault_i) begin
      sts_d.ec   = fault_stage2_i ? EC_S2 : EC_S1;
      sts_d.code = fault_code_i;
      sts_d.stop = 1'b1;
      sts_d.irq  = 1'b1;
    end else if (!sts_d.stop && (trig_i || man_stop_i || (wrap_ev_i && fill_mode_i))) begin
      sts_d.ec   = EC_BUF;
      sts_d.stop = 1'b1;
      sts_d.irq  = 1'b1;
      if (wrap_ev_i && fill_mode_i) sts_d.code = CODE_FILL;
      else if (trig_i)              sts_d.code = CODE_TRIG;
      else                          sts_d.code = CODE_MAN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R4
  trg_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q.trg && !sw_we_i |=> sts_q.trg);

  // R12
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q.stop && !sw_we_i && !fault_i |=> sts_q.stop && $stable(sts_q.code));

  // R8
  irq_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_q.stop && !sw_we_i ##1 sts_q.stop |-> sts_q.irq);
endmodule

// File: rtl/tbuf_wr_status.sv
module tbuf_wr_status
  import tbuf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] byte_data_i,
  output logic          byte_ready_o,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic          ptr_load_i,
  input  logic          wrap_mode_i,
  input  logic          trig_i,
  input  logic          man_stop_i,
  input  logic          fault_i,
  input  logic          fault_stage2_i,
  input  logic [5:0]    fault_code_i,
  input  logic          sts_we_i,
  input  logic [63:0]   sts_wdata_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  input  logic          mem_ready_i,
  output logic          irq_o,
  output logic [63:0]   status_o
);
  tbuf_sts_t     sts;
  logic          accept;
  logic          hold_full;
  logic          wrap_ev;
  logic [AW-1:0] wp;

  assign byte_ready_o = !sts.stop && (!hold_full || mem_ready_i);
  assign accept       = byte_valid_i && byte_ready_o;

  tbuf_ptr #(.AW(AW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ptr_load_i),
    .base_i  (base_i),
    .limit_i (limit_i),
    .acc_i   (accept),
    .wp_o    (wp),
    .wrap_o  (wrap_ev)
  );

  tbuf_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (accept),
    .addr_i      (wp),
    .data_i      (byte_data_i),
    .mem_ready_i (mem_ready_i),
    .full_o      (hold_full),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o)
  );

  tbuf_stat u_stat (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wrap_ev_i      (wrap_ev),
    .fill_mode_i    (!wrap_mode_i),
    .trig_i         (trig_i),
    .man_stop_i     (man_stop_i),
    .fault_i        (fault_i),
    .fault_stage2_i (fault_stage2_i),
    .fault_code_i   (fault_code_i),
    .sw_we_i        (sts_we_i),
    .sw_wdata_i     (sts_wdata_i),
    .sts_o          (sts)
  );

  assign status_o = pack_status(sts, hold_full);
  assign irq_o    = sts.irq;

  // R7
  no_accept_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[STOP_BIT] && !mem_we_o |=> !mem_we_o);
endmodule

// File: tb/tbuf_wr_status_tb.sv
`timescale 1ns/1ps
module tbuf_wr_status_tb;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          byte_valid = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          byte_ready;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] limit = '0;
  logic          ptr_load = 1'b0;
  logic          wrap_mode = 1'b1;
  logic          trig = 1'b0;
  logic          man_stop = 1'b0;
  logic          fault = 1'b0;
  logic          fault_s2 = 1'b0;
  logic [5:0]    fault_code = '0;
  logic          sts_we = 1'b0;
  logic [63:0]   sts_wdata = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ready = 1'b1;
  logic          irq;
  logic [63:0]   status;

  int n_run = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  logic [AW-1:0] log_addr [0:255];
  logic [DW-1:0] log_data [0:255];

  always #2.5 clk = ~clk;

  tbuf_wr_status #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_ready_o(byte_ready),
    .base_i(base), .limit_i(limit), .ptr_load_i(ptr_load), .wrap_mode_i(wrap_mode),
    .trig_i(trig), .man_stop_i(man_stop), .fault_i(fault), .fault_stage2_i(fault_s2),
    .fault_code_i(fault_code), .sts_we_i(sts_we), .sts_wdata_i(sts_wdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_ready_i(mem_ready), .irq_o(irq), .status_o(status)
  );

  always @(negedge clk) begin
    #1;
    if (rst_ni && mem_we && mem_ready && wr_cnt < 256) begin
      log_addr[wr_cnt] = mem_addr;
      log_data[wr_cnt] = mem_data;
      wr_cnt++;
    end
  end

  function automatic logic [63:0] mk(logic [5:0] ec, logic dat, logic irq_b, logic trg,
                                     logic wrp, logic s, logic [5:0] code);
    logic [63:0] w = '0;
    w[31:26] = ec; w[23] = dat; w[22] = irq_b; w[21] = trg;
    w[20] = wrp; w[17] = s; w[5:0] = code;
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [DW-1:0] d, output bit ok);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data = d;
    ok = byte_ready;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic swr(logic [63:0] v);
    @(negedge clk); sts_we = 1'b1; sts_wdata = v;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic load(logic [AW-1:0] b, logic [AW-1:0] l);
    @(negedge clk); base = b; limit = l; ptr_load = 1'b1;
    @(negedge clk); ptr_load = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    int acc, n0;
    logic [AW-1:0] bases [0:2];
    logic [AW-1:0] lims  [0:2];
    bases[0] = 8'd0;  lims[0] = 8'd3;
    bases[1] = 8'd4;  lims[1] = 8'd12;
    bases[2] = 8'd10; lims[2] = 8'd11;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 status", status, 64'd0);
    chk("R11 irq", {63'd0, irq}, 64'd0);
    chk("R11 ready", {63'd0, byte_ready}, 64'd1);
    chk("R11 we", {63'd0, mem_we}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 wrap-mode sweep over regions
    for (int p = 0; p < 3; p++) begin
      int span;
      span = int'(lims[p]) - int'(bases[p]);
      swr(64'd0);
      wrap_mode = 1'b1;
      load(bases[p], lims[p]);
      n0 = wr_cnt;
      for (int i = 0; i < 12; i++) send(DW'(p * 16 + i), ok);
      idle();
      @(negedge clk);
      chk("R1 count", 64'(wr_cnt - n0), 64'd12);
      for (int i = 0; i < 12; i++) begin
        chk("R1 addr", 64'(log_addr[n0 + i]), 64'(int'(bases[p]) + (i % span)));
        chk("R1 data", 64'(log_data[n0 + i]), 64'(p * 16 + i));
      end
      chk("R2 status", status, mk(6'd0, 0, 0, 0, 1, 0, 6'd0));
      chk("R2 ready", {63'd0, byte_ready}, 64'd1);
    end

    // R3 fill mode
    swr(64'd0);
    wrap_mode = 1'b0;
    load(8'd2, 8'd7);
    n0 = wr_cnt; acc = 0;
    for (int i = 0; i < 8; i++) begin send(DW'(8'h40 + i), ok); acc += int'(ok); end
    idle();
    @(negedge clk);
    chk("R3 accepted", 64'(acc), 64'd5);
    chk("R3 written", 64'(wr_cnt - n0), 64'd5);
    for (int i = 0; i < 5; i++) chk("R3 addr", 64'(log_addr[n0 + i]), 64'(2 + i));
    chk("R3 status", status, mk(6'd0, 0, 1, 0, 1, 1, 6'd1));
    chk("R8 irq", {63'd0, irq}, 64'd1);
    // R7 stopped drops bytes
    chk("R7 ready", {63'd0, byte_ready}, 64'd0);
    n0 = wr_cnt;
    send(8'hEE, ok); send(8'hEF, ok); idle();
    @(negedge clk);
    chk("R7 no write", 64'(wr_cnt - n0), 64'd0);
    // R8 irq cleared by write, stop kept
    swr(mk(6'd0, 0, 0, 0, 1, 1, 6'd1));
    chk("R8 irq clear", {63'd0, irq}, 64'd0);
    chk("R8 status", status, mk(6'd0, 0, 0, 0, 1, 1, 6'd1));

    // R9 pending data
    swr(64'd0);
    wrap_mode = 1'b1;
    load(8'd0, 8'd16);
    mem_ready = 1'b0;
    send(8'hA5, ok);
    idle();
    chk("R9 dat", status, mk(6'd0, 1, 0, 0, 0, 0, 6'd0));
    @(negedge clk);
    chk("R9 held", {mem_we, 7'd0, mem_addr, mem_data}, {1'b1, 7'd0, 8'd0, 8'hA5});
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b1;
    chk("R9 drained", status, 64'd0);

    // R4 trigger
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk("R4 trigger", status, mk(6'd0, 0, 1, 1, 0, 1, 6'd2));

    // R5 manual stop, R12 later trigger keeps code
    swr(64'd0);
    @(negedge clk); man_stop = 1'b1; @(negedge clk); man_stop = 1'b0;
    chk("R5 manual", status, mk(6'd0, 0, 1, 0, 0, 1, 6'd3));
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
    chk("R12 keep code", status, mk(6'd0, 0, 1, 1, 0, 1, 6'd3));

    // R12 simultaneous trigger and manual
    swr(64'd0);
    @(negedge clk); trig = 1'b1; man_stop = 1'b1;
    @(negedge clk); trig = 1'b0; man_stop = 1'b0;
    chk("R12 priority", status, mk(6'd0, 0, 1, 1, 0, 1, 6'd2));

    // R6 faults
    swr(64'd0);
    @(negedge clk); fault = 1'b1; fault_s2 = 1'b0; fault_code = 6'h0D;
    @(negedge clk); fault = 1'b0;
    chk("R6 stage1", status, mk(6'h24, 0, 1, 0, 0, 1, 6'h0D));
    @(negedge clk); fault = 1'b1; fault_s2 = 1'b1; fault_code = 6'h07;
    @(negedge clk); fault = 1'b0;
    chk("R6 stage2", status, mk(6'h25, 0, 1, 0, 0, 1, 6'h07));

    // R10 software write fields, reserved bits
    swr({64{1'b1}});
    chk("R10 all ones", status, mk(6'h3F, 0, 1, 1, 1, 1, 6'h3F));
    @(negedge clk); sts_we = 1'b1; sts_wdata = 64'd0; trig = 1'b1;
    @(negedge clk); sts_we = 1'b0; trig = 1'b0;
    chk("R10 hw wins", status, mk(6'd0, 0, 1, 1, 0, 1, 6'd2));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule